// File: doc/BRIEF.md
# Thread Context Allocator with Yield Handling

This block keeps a small table of hardware thread contexts. For each one it records the processor the context is bound to, whether the context may be handed out on demand, whether it is halted, whether it is activated, and a per-context debug flag. A requesting thread issues one of two operations. A fork operation takes the lowest-numbered free context on the issuer's own processor. It activates that context and stores a restart address, a destination register index and a data word for it. A yield operation either releases the issuer's context, or parks it on a qualifier wait condition, or asks for rescheduling, or only samples the enabled qualifier inputs. The choice depends on the signed operand.

Any illegal case becomes a single-cycle thread exception with a 3-bit cause code, or a reserved-operation indication. Every result appears on registered outputs one clock after the request. A configuration write port loads context entries, and a peek port shows one entry at a time. Scheduling policy and instruction execution belong to the surrounding core.

Top module: `tctx_alloc`

## Requirements
- R1: A fork (reqOp = 2'b01) takes the lowest-index context that meets all four conditions: bound to the same processor as the issuer, allocatable, not halted and not activated. The following cycle shows forkOk = 1 and forkCtx = that index.
- R2: A successful fork stores reqRs as the chosen context's restart address, reqRd as its register index and reqRt as its data word, and sets its activated flag.
- R3: A fork with no qualifying context changes no context and raises excValid with excCause = 3'd1.
- R4: A yield (reqOp = 2'b10) with operand 0 clears the issuer's activated flag when another activated, allocatable, non-halted context exists on the same processor. Otherwise it raises excCause = 3'd0 and leaves the flag set.
- R5: A positive yield operand with any bit set outside the qualifier mask raises excCause = 3'd2 and does not block the context.
- R6: A valid positive yield operand blocks the issuer. The block clears at the first clock edge where (qualIn AND operand AND mask) is nonzero.
- R7: Operand -1, operand 0 (when it succeeds) and a valid positive operand pulse schedReq. Operand -2 never does.
- R8: When a yield would pulse schedReq while yieldIntercept and the issuer's debug flag are both 1, the block raises excCause = 3'd4 instead. No context state changes and no writeback occurs. Operand -2 never raises this exception.
- R9: A yield that raises no exception and no reserved indication, with reqRd nonzero, pulses wbValid. It returns wbReg = reqRd and wbData = qualIn AND mask, with unmasked bits 0. With reqRd = 0 there is no writeback.
- R10: A yield operand of -3 or below pulses rsvdInstr. It raises no exception, performs no writeback and changes no state.
- R11: After reset every context is clear (not activated, not blocked) and every response output is 0.
- R12: All response outputs are registered and valid in the cycle after the request. respValid follows each request by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write one context entry |
| cfgCtx | input | CW | Entry to write |
| cfgVpe | input | VPE_W | Bound processor id |
| cfgDa | input | 1 | Allocatable flag |
| cfgHalt | input | 1 | Halted flag |
| cfgAct | input | 1 | Activated flag |
| cfgDbg | input | 1 | Debug flag |
| yieldIntercept | input | 1 | Trap rescheduling yields of debug contexts |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 01 fork, 10 yield |
| reqCtx | input | CW | Issuing context |
| reqRs | input | DW | Restart address (fork) or signed yield operand |
| reqRt | input | DW | Data word for the forked context |
| reqRd | input | RW | Register index |
| qualIn | input | QW | Qualifier inputs |
| qualMask | input | QW | Enabled qualifier mask |
| peekCtx | input | CW | Entry shown on the peek outputs |
| peekAct | output | 1 | Activated flag of the peeked entry |
| peekBlocked | output | 1 | Blocked flag of the peeked entry |
| peekRestart | output | DW | Restart address of the peeked entry |
| peekDataReg | output | RW | Stored register index |
| peekDataVal | output | DW | Stored data word |
| respValid | output | 1 | Response strobe |
| forkOk | output | 1 | Fork succeeded |
| forkCtx | output | CW | Allocated context |
| excValid | output | 1 | Thread exception |
| excCause | output | 3 | Exception cause |
| rsvdInstr | output | 1 | Reserved operand indication |
| schedReq | output | 1 | Rescheduling requested |
| wbValid | output | 1 | Writeback strobe |
| wbReg | output | RW | Writeback register |
| wbData | output | DW | Masked qualifier value |

## Verification
The fork tests use two table layouts:
- A layout where the lowest free index sits behind a context bound to another processor and a halted context. This tells a true first-free search on the issuer's processor apart from a plain lowest-free pick.
- A full table. This separates overflow from a stale choice.

The yield tests cover each operand class: zero with and without an active peer, a positive operand inside and outside the mask, -1, -2, and -3. Each class has its own outcome, so swapped classes are detected. A qualifier input that does not match the wait condition is applied before one that does, which tells the real wait condition apart from any-input wake-up. Intercept runs with -1 and -2 separate the two rescheduling classes.

// File: rtl/tctx_pkg.sv
`timescale 1ns/1ps
package tctx_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_FORK  = 2'b01,
    OP_YIELD = 2'b10
  } tctx_op_e;

  localparam logic [2:0] CAUSE_UNDERFLOW = 3'd0;
  localparam logic [2:0] CAUSE_OVERFLOW  = 3'd1;
  localparam logic [2:0] CAUSE_BADQUAL   = 3'd2;
  localparam logic [2:0] CAUSE_INTERCEPT = 3'd4;

  typedef struct packed {
    logic allocEn;
    logic releaseEn;
    logic blockEn;
  } tctx_strobe_t;
endpackage

// File: rtl/tctx_table.sv
`timescale 1ns/1ps
module tctx_table import tctx_pkg::*; #(
  parameter int NCTX  = 8,
  parameter int VPE_W = 2,
  parameter int DW    = 32,
  parameter int QW    = 31,
  parameter int RW    = 5,
  localparam int CW   = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CW-1:0]    cfgCtx,
  input  logic [VPE_W-1:0] cfgVpe,
  input  logic             cfgDa,
  input  logic             cfgHalt,
  input  logic             cfgAct,
  input  logic             cfgDbg,
  input  logic [CW-1:0]    reqCtx,
  input  logic [DW-1:0]    reqRs,
  input  logic [DW-1:0]    reqRt,
  input  logic [RW-1:0]    reqRd,
  input  logic [QW-1:0]    waitMask,
  input  logic [QW-1:0]    qualIn,
  input  tctx_strobe_t     strobe,
  input  logic [CW-1:0]    peekCtx,
  output logic             freeFound,
  output logic [CW-1:0]    freeIdx,
  output logic             peerActive,
  output logic             callerDbg,
  output logic             peekAct,
  output logic             peekBlocked,
  output logic [DW-1:0]    peekRestart,
  output logic [RW-1:0]    peekDataReg,
  output logic [DW-1:0]    peekDataVal
);
  logic [VPE_W-1:0] vpeId    [NCTX];
  logic [QW-1:0]    waitCond [NCTX];
  logic [DW-1:0]    restart  [NCTX];
  logic [RW-1:0]    dataReg  [NCTX];
  logic [DW-1:0]    dataVal  [NCTX];
  logic [NCTX-1:0]  da, halt, act, dbg, blocked;
  logic [VPE_W-1:0] issuerVpe;
  logic [NCTX-1:0]  freeVec, peerVec;

  assign issuerVpe = vpeId[reqCtx];
  assign callerDbg = dbg[reqCtx];

  for (genvar g = 0; g < NCTX; g++) begin : g_qual
    assign freeVec[g] = (vpeId[g] == issuerVpe) && da[g] && !halt[g] && !act[g];
    assign peerVec[g] = (vpeId[g] == issuerVpe) && da[g] && !halt[g] && act[g]
                        && (CW'(g) != reqCtx);
  end

  assign peerActive = |peerVec;

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (!freeFound && freeVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = CW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      da <= '0; halt <= '0; act <= '0; dbg <= '0; blocked <= '0;
      for (int i = 0; i < NCTX; i++) begin
        vpeId[i] <= '0; waitCond[i] <= '0; restart[i] <= '0;
        dataReg[i] <= '0; dataVal[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCTX; i++) begin
        if (cfgWe && cfgCtx == CW'(i)) begin
          vpeId[i] <= cfgVpe;
          da[i]    <= cfgDa;
          halt[i]  <= cfgHalt;
          act[i]   <= cfgAct;
          dbg[i]   <= cfgDbg;
        end else begin
          if (strobe.allocEn && freeIdx == CW'(i)) begin
            act[i]     <= 1'b1;
            restart[i] <= reqRs;
            dataReg[i] <= reqRd;
            dataVal[i] <= reqRt;
          end
          if (strobe.releaseEn && reqCtx == CW'(i)) act[i] <= 1'b0;
        end
        if (strobe.blockEn && reqCtx == CW'(i)) begin
          blocked[i]  <= 1'b1;
          waitCond[i] <= waitMask;
        end else if (blocked[i] && |(qualIn & waitCond[i])) begin
          blocked[i] <= 1'b0;
        end
      end
    end
  end

  assign peekAct     = act[peekCtx];
  assign peekBlocked = blocked[peekCtx];
  assign peekRestart = restart[peekCtx];
  assign peekDataReg = dataReg[peekCtx];
  assign peekDataVal = dataVal[peekCtx];
endmodule

// File: rtl/tctx_ctrl.sv
`timescale 1ns/1ps
module tctx_ctrl import tctx_pkg::*; #(
  parameter int CW = 3,
  parameter int DW = 32,
  parameter int QW = 31,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [DW-1:0] reqRs,
  input  logic [RW-1:0] reqRd,
  input  logic [QW-1:0] qualIn,
  input  logic [QW-1:0] qualMask,
  input  logic          yieldIntercept,
  input  logic          freeFound,
  input  logic [CW-1:0] freeIdx,
  input  logic          peerActive,
  input  logic          callerDbg,
  output tctx_strobe_t  strobe,
  output logic [QW-1:0] waitMask,
  output logic          respValid,
  output logic          forkOk,
  output logic [CW-1:0] forkCtx,
  output logic          excValid,
  output logic [2:0]    excCause,
  output logic          rsvdInstr,
  output logic          schedReq,
  output logic          wbValid,
  output logic [RW-1:0] wbReg,
  output logic [DW-1:0] wbData
);
  localparam logic [DW-1:0] MINUS_TWO = {{(DW-1){1'b1}}, 1'b0};

  logic [DW-1:0] maskExt;
  logic isFork, isYield, rsZero, rsM1, rsM2, rsPos, rsRsv, extraBits;
  logic underflow, badQual, overflow, resched, intercept, excAny;
  logic [2:0] causeN;

  assign maskExt   = DW'(qualMask);
  assign extraBits = |(reqRs & ~maskExt);
  assign waitMask  = reqRs[QW-1:0] & qualMask;

  assign isFork  = reqValid && (reqOp == OP_FORK);
  assign isYield = reqValid && (reqOp == OP_YIELD);
  assign rsZero  = (reqRs == '0);
  assign rsM1    = (reqRs == '1);
  assign rsM2    = (reqRs == MINUS_TWO);
  assign rsPos   = !reqRs[DW-1] && !rsZero;
  assign rsRsv   = reqRs[DW-1] && !rsM1 && !rsM2;

  assign overflow  = isFork && !freeFound;
  assign underflow = isYield && rsZero && !peerActive;
  assign badQual   = isYield && rsPos && extraBits;
  assign resched   = isYield && ((rsZero && peerActive) || (rsPos && !extraBits) || rsM1);
  assign intercept = resched && yieldIntercept && callerDbg;
  assign excAny    = overflow || underflow || badQual || intercept;

  always_comb begin
    causeN = CAUSE_UNDERFLOW;
    if (overflow)       causeN = CAUSE_OVERFLOW;
    else if (badQual)   causeN = CAUSE_BADQUAL;
    else if (intercept) causeN = CAUSE_INTERCEPT;
  end

  always_comb begin
    strobe.allocEn   = isFork && freeFound;
    strobe.releaseEn = isYield && rsZero && peerActive && !intercept;
    strobe.blockEn   = isYield && rsPos && !extraBits && !intercept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0; forkOk <= 1'b0; forkCtx <= '0;
      excValid <= 1'b0; excCause <= '0; rsvdInstr <= 1'b0;
      schedReq <= 1'b0; wbValid <= 1'b0; wbReg <= '0; wbData <= '0;
    end else begin
      respValid <= reqValid;
      forkOk    <= isFork && freeFound;
      forkCtx   <= isFork ? freeIdx : '0;
      excValid  <= excAny;
      excCause  <= excAny ? causeN : 3'd0;
      rsvdInstr <= isYield && rsRsv;
      schedReq  <= resched && !intercept;
      wbValid   <= isYield && !rsRsv && !excAny && (reqRd != '0);
      wbReg     <= reqRd;
      wbData    <= DW'(qualIn & qualMask);
    end
  end
endmodule

// File: rtl/tctx_alloc.sv
`timescale 1ns/1ps
module tctx_alloc import tctx_pkg::*; #(
  parameter int NCTX  = 8,
  parameter int VPE_W = 2,
  parameter int DW    = 32,
  parameter int QW    = 31,
  parameter int RW    = 5,
  localparam int CW   = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CW-1:0]    cfgCtx,
  input  logic [VPE_W-1:0] cfgVpe,
  input  logic             cfgDa,
  input  logic             cfgHalt,
  input  logic             cfgAct,
  input  logic             cfgDbg,
  input  logic             yieldIntercept,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [CW-1:0]    reqCtx,
  input  logic [DW-1:0]    reqRs,
  input  logic [DW-1:0]    reqRt,
  input  logic [RW-1:0]    reqRd,
  input  logic [QW-1:0]    qualIn,
  input  logic [QW-1:0]    qualMask,
  input  logic [CW-1:0]    peekCtx,
  output logic             peekAct,
  output logic             peekBlocked,
  output logic [DW-1:0]    peekRestart,
  output logic [RW-1:0]    peekDataReg,
  output logic [DW-1:0]    peekDataVal,
  output logic             respValid,
  output logic             forkOk,
  output logic [CW-1:0]    forkCtx,
  output logic             excValid,
  output logic [2:0]       excCause,
  output logic             rsvdInstr,
  output logic             schedReq,
  output logic             wbValid,
  output logic [RW-1:0]    wbReg,
  output logic [DW-1:0]    wbData
);
  tctx_strobe_t  strobe;
  logic [QW-1:0] waitMask;
  logic          freeFound, peerActive, callerDbg;
  logic [CW-1:0] freeIdx;

  tctx_ctrl #(.CW(CW), .DW(DW), .QW(QW), .RW(RW)) u_ctrl (
    .clk, .rstN, .reqValid, .reqOp, .reqRs, .reqRd, .qualIn, .qualMask,
    .yieldIntercept, .freeFound, .freeIdx, .peerActive, .callerDbg,
    .strobe, .waitMask, .respValid, .forkOk, .forkCtx, .excValid,
    .excCause, .rsvdInstr, .schedReq, .wbValid, .wbReg, .wbData
  );

  tctx_table #(.NCTX(NCTX), .VPE_W(VPE_W), .DW(DW), .QW(QW), .RW(RW)) u_table (
    .clk, .rstN, .cfgWe, .cfgCtx, .cfgVpe, .cfgDa, .cfgHalt, .cfgAct, .cfgDbg,
    .reqCtx, .reqRs, .reqRt, .reqRd, .waitMask, .qualIn, .strobe, .peekCtx,
    .freeFound, .freeIdx, .peerActive, .callerDbg, .peekAct, .peekBlocked,
    .peekRestart, .peekDataReg, .peekDataVal
  );
endmodule

// File: rtl/tctx_alloc_chk.sv
`timescale 1ns/1ps
module tctx_alloc_chk #(
  parameter int DW = 32,
  parameter int QW = 31,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [QW-1:0] qualMask,
  input logic          respValid,
  input logic          forkOk,
  input logic          excValid,
  input logic [2:0]    excCause,
  input logic          rsvdInstr,
  input logic          schedReq,
  input logic          wbValid,
  input logic [RW-1:0] wbReg,
  input logic [DW-1:0] wbData
);
  a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid));
  a_r12_no_orphan_exc: assert property (@(posedge clk) disable iff (!rstN)
    (excValid || forkOk || wbValid || rsvdInstr || schedReq) |-> respValid);
  a_r3_cause_legal: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCause == 3'd0 || excCause == 3'd1 || excCause == 3'd2 || excCause == 3'd4));
  a_r9_wb_masked: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ((wbData & ~DW'($past(qualMask))) == '0));
  a_r9_wb_clean: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (!excValid && wbReg != '0));
  a_r10_rsvd_alone: assert property (@(posedge clk) disable iff (!rstN)
    rsvdInstr |-> (!excValid && !wbValid && !schedReq));
  a_r1_fork_clean: assert property (@(posedge clk) disable iff (!rstN)
    forkOk |-> !excValid);
  a_r8_sched_clean: assert property (@(posedge clk) disable iff (!rstN)
    schedReq |-> !excValid);
endmodule

bind tctx_alloc tctx_alloc_chk #(.DW(DW), .QW(QW), .RW(RW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .qualMask(qualMask),
  .respValid(respValid), .forkOk(forkOk), .excValid(excValid),
  .excCause(excCause), .rsvdInstr(rsvdInstr), .schedReq(schedReq),
  .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData)
);

// File: tb/tctx_alloc_test.sv
`timescale 1ns/1ps
module tctx_alloc_test;
  localparam int NCTX = 8, VPE_W = 2, DW = 32, QW = 31, RW = 5, CW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, cfgDa = 0, cfgHalt = 0, cfgAct = 0, cfgDbg = 0, yieldIntercept = 0;
  logic [CW-1:0] cfgCtx = '0, reqCtx = '0, peekCtx = '0;
  logic [VPE_W-1:0] cfgVpe = '0;
  logic reqValid = 0;
  logic [1:0] reqOp = 2'b00;
  logic [DW-1:0] reqRs = '0, reqRt = '0;
  logic [RW-1:0] reqRd = '0;
  logic [QW-1:0] qualIn = '0, qualMask = '0;
  logic peekAct, peekBlocked, respValid, forkOk, excValid, rsvdInstr, schedReq, wbValid;
  logic [DW-1:0] peekRestart, peekDataVal, wbData;
  logic [RW-1:0] peekDataReg, wbReg;
  logic [CW-1:0] forkCtx;
  logic [2:0] excCause;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tctx_alloc #(.NCTX(NCTX), .VPE_W(VPE_W), .DW(DW), .QW(QW), .RW(RW)) uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int idx, int vpe, bit da, bit hlt, bit ac, bit dg);
    @(negedge clk);
    cfgWe = 1; cfgCtx = CW'(idx); cfgVpe = VPE_W'(vpe);
    cfgDa = da; cfgHalt = hlt; cfgAct = ac; cfgDbg = dg;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic req(logic [1:0] op, int ctx, logic [DW-1:0] rs, logic [DW-1:0] rt, int rd);
    @(negedge clk);
    reqValid = 1; reqOp = op; reqCtx = CW'(ctx); reqRs = rs; reqRt = rt; reqRd = RW'(rd);
    @(negedge clk);
    reqValid = 0; reqOp = 2'b00;
  endtask

  task automatic t_reset;
    peekCtx = 3'd3;
    #1;
    check("R11 respValid", respValid, 0);
    check("R11 peekAct", peekAct, 0);
    check("R11 peekBlocked", peekBlocked, 0);
  endtask

  task automatic t_fork_priority;
    cfg(0, 0, 0, 0, 1, 0);
    cfg(1, 1, 1, 0, 0, 0);
    cfg(2, 0, 1, 1, 0, 0);
    cfg(3, 0, 1, 0, 0, 0);
    cfg(4, 0, 1, 0, 0, 0);
    req(2'b01, 0, 32'h0000_4000, 32'hCAFE_0001, 7);
    check("R12 respValid", respValid, 1);
    check("R1 forkOk", forkOk, 1);
    check("R1 first free is 3", forkCtx, 3);
    peekCtx = 3'd3; #1;
    check("R2 restart", peekRestart, 32'h0000_4000);
    check("R2 dataReg", peekDataReg, 7);
    check("R2 dataVal", peekDataVal, 32'hCAFE_0001);
    check("R2 activated", peekAct, 1);
    req(2'b01, 0, 32'h0000_5000, 32'h1234, 2);
    check("R1 next free is 4", forkCtx, 4);
  endtask

  task automatic t_fork_overflow;
    req(2'b01, 0, 32'h9, 32'h9, 1);
    check("R3 excValid", excValid, 1);
    check("R3 cause", excCause, 1);
    check("R3 forkOk", forkOk, 0);
    peekCtx = 3'd1; #1;
    check("R3 other-processor ctx untouched", peekAct, 0);
  endtask

  task automatic t_yield_zero;
    req(2'b10, 3, 32'h0, 32'h0, 0);
    check("R4 release no exc", excValid, 0);
    check("R7 sched on release", schedReq, 1);
    peekCtx = 3'd3; #1;
    check("R4 ctx3 released", peekAct, 0);
    req(2'b10, 4, 32'h0, 32'h0, 0);
    check("R4 underflow exc", excValid, 1);
    check("R4 underflow cause", excCause, 0);
    peekCtx = 3'd4; #1;
    check("R4 ctx4 kept", peekAct, 1);
  endtask

  task automatic t_yield_qual;
    qualMask = 31'h0F; qualIn = '0;
    req(2'b10, 4, 32'h10, 32'h0, 0);
    check("R5 bad qualifier exc", excValid, 1);
    check("R5 cause", excCause, 2);
    peekCtx = 3'd4; #1;
    check("R5 not blocked", peekBlocked, 0);
    req(2'b10, 4, 32'h06, 32'h0, 0);
    check("R6 no exc", excValid, 0);
    check("R7 sched on wait", schedReq, 1);
    #1;
    check("R6 blocked", peekBlocked, 1);
    qualIn = 31'h01;
    @(negedge clk); #1;
    check("R6 nonmatching input keeps block", peekBlocked, 1);
    qualIn = 31'h04;
    @(negedge clk); #1;
    check("R6 matching input resumes", peekBlocked, 0);
    qualIn = '0;
  endtask

  task automatic t_yield_poll;
    qualIn = 31'hFF;
    req(2'b10, 4, 32'hFFFF_FFFF, 32'h0, 5);
    check("R7 -1 sched", schedReq, 1);
    check("R9 wbValid", wbValid, 1);
    check("R9 wbReg", wbReg, 5);
    check("R9 wbData masked", wbData, 32'h0F);
    req(2'b10, 4, 32'hFFFF_FFFE, 32'h0, 0);
    check("R7 -2 no sched", schedReq, 0);
    check("R9 rd0 no wb", wbValid, 0);
    check("R7 -2 no exc", excValid, 0);
    qualIn = '0;
  endtask

  task automatic t_intercept;
    cfg(4, 0, 1, 0, 1, 1);
    yieldIntercept = 1;
    req(2'b10, 4, 32'hFFFF_FFFF, 32'h0, 3);
    check("R8 intercept exc", excValid, 1);
    check("R8 cause", excCause, 4);
    check("R8 no sched", schedReq, 0);
    check("R8 no wb", wbValid, 0);
    req(2'b10, 4, 32'hFFFF_FFFE, 32'h0, 3);
    check("R8 -2 no exc", excValid, 0);
    check("R8 -2 wb", wbValid, 1);
    yieldIntercept = 0;
  endtask

  task automatic t_reserved;
    req(2'b10, 4, 32'hFFFF_FFFD, 32'h0, 6);
    check("R10 rsvd", rsvdInstr, 1);
    check("R10 no exc", excValid, 0);
    check("R10 no wb", wbValid, 0);
    peekCtx = 3'd4; #1;
    check("R10 ctx4 unchanged", peekAct, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    t_fork_priority();
    t_fork_overflow();
    t_yield_zero();
    t_yield_qual();
    t_yield_poll();
    t_intercept();
    t_reserved();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule